// File: doc/BRIEF.md
# Borrow-Weighted Column Counter with One-Hot Digit Adder

This block is a purely combinational column counter for reducing partial products. Five single-bit inputs enter it. One of them, the borrow bit, counts as two, and the four unit bits count as one each. A single in-stage carry from the neighbouring instance adds one more. The block splits the weighted total into two parts: a low digit, coded as four lines with exactly one line high, and a binary carry-out of weight four that goes on to the next instance in the same stage.

Beside the counter sits an embedded full-adder stage that works on one-hot digits directly. It takes a digit produced two columns higher, a digit produced one column higher, and a binary bit from the current column. All three carry the same weight. The stage returns one one-hot digit and one binary carry of weight four. No conversion to or from binary is done. Instances are tiled along a reduction row, and the carries are wired between neighbours.

Top module: `bwpc_column`

## Requirements
- R1: `cnt_dig_o` always has exactly one line high. Line k high means the digit value k, for k from 0 to 3.
- R2: The borrow bit counts two, and every unit bit and `cin_i` count one. The digit value plus four times `cnt_cout_o` equals the weighted input total.
- R3: The value of `cnt_dig_o` is the weighted input total modulo 4, coded with line k for value k.
- R4: `cnt_cout_o` is high exactly when the weighted input total is 4 or more. With four unit bits the total never exceeds 7.
- R5: With all counter inputs low, `cnt_dig_o` is 4'b0001 and `cnt_cout_o` is 0. With all counter inputs high, `cnt_dig_o` is 4'b1000 and `cnt_cout_o` is 1.
- R6: `hi2_dig_i` and `hi1_dig_i` must each have exactly one line high, with line k meaning value k. Any other code is illegal and the adder outputs are then don't-care.
- R7: `fa_dig_o` always has exactly one line high. Its value plus four times `fa_cout_o` equals the value of `hi2_dig_i` plus the value of `hi1_dig_i` plus `q_i`.
- R8: `fa_cout_o` is high exactly when that adder sum is 4 or more. The largest case is 3 + 3 + 1, which gives digit 4'b1000 with the carry high.
- R9: The counter and the adder do not depend on each other. Changing only the adder inputs leaves `cnt_dig_o` and `cnt_cout_o` unchanged, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| borrow_i | input | 1 | Borrow bit, weight two |
| unit_i | input | N_UNIT (4) | Unit bits, weight one each |
| cin_i | input | 1 | In-stage carry from the neighbour, weight one |
| hi2_dig_i | input | 4 | One-hot digit from two columns higher |
| hi1_dig_i | input | 4 | One-hot digit from one column higher |
| q_i | input | 1 | Binary bit from this column, same weight as the digits |
| cnt_dig_o | output | 4 | One-hot low digit of the counter |
| cnt_cout_o | output | COUT_W (1) | Counter carry-out, weight four |
| fa_dig_o | output | 4 | One-hot digit of the embedded adder |
| fa_cout_o | output | 1 | Adder carry-out, weight four |

## Verification
The counter and the embedded adder settle from the same input change, so both are evaluated in every bench cycle. The bench sweeps all 64 combinations of borrow, unit and carry-in bits. In the same cycles it steps through the 32 legal adder input combinations, first in plain order and then in a scrambled order, so each counter pattern meets different adder patterns. Each output pair is compared separately against its own arithmetic reference. A final phase holds one side's inputs still while it moves the other side's inputs, and checks that the held side's outputs stay unchanged.

// File: rtl/bwpc_pkg.sv
package bwpc_pkg;

  localparam int unsigned DIG_W = 4;

  typedef logic [DIG_W-1:0] digit_t;

  // value in 0..3 -> one-hot line (value taken modulo 4)
  function automatic digit_t oh_of(input int unsigned v);
    return digit_t'(4'b0001 << (v % DIG_W));
  endfunction

  // one-hot line -> value (lowest high line wins)
  function automatic int unsigned val_of(input digit_t d);
    int unsigned r;
    r = 0;
    for (int k = DIG_W - 1; k >= 0; k--) begin
      if (d[k]) r = k;
    end
    return r;
  endfunction

  function automatic bit oh_ok(input digit_t d);
    return $countones(d) == 1;
  endfunction

endpackage

// File: rtl/bwpc_in_tally.sv
module bwpc_in_tally #(
  parameter int unsigned N_UNIT = 4,
  parameter int unsigned TOT_W  = 3
) (
  input  logic              borrow_i,
  input  logic [N_UNIT-1:0] unit_i,
  input  logic              cin_i,
  output logic [TOT_W-1:0]  total_o
);

  // running sums: seed holds borrow (weight 2) and carry-in (weight 1)
  logic [TOT_W-1:0] acc [N_UNIT+1];

  assign acc[0] = TOT_W'({borrow_i, cin_i});

  for (genvar k = 0; k < N_UNIT; k++) begin : g_acc
    assign acc[k+1] = acc[k] + TOT_W'(unit_i[k]);
  end

  assign total_o = acc[N_UNIT];

endmodule

// File: rtl/bwpc_digit_split.sv
module bwpc_digit_split
  import bwpc_pkg::*;
#(
  parameter int unsigned TOT_W  = 3,
  parameter int unsigned COUT_W = 1
) (
  input  logic [TOT_W-1:0]  total_i,
  output digit_t            dig_o,
  output logic [COUT_W-1:0] cout_o
);

  for (genvar k = 0; k < DIG_W; k++) begin : g_line
    assign dig_o[k] = (total_i[1:0] == 2'(k));
  end

  assign cout_o = total_i[TOT_W-1:2];

endmodule

// File: rtl/bwpc_oh_adder.sv
module bwpc_oh_adder
  import bwpc_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  input  logic   q_i,
  output digit_t dig_o,
  output logic   cout_o
);

  // named internal events for the checks
  digit_t ab_dig;   // a + b modulo 4, still one-hot
  logic   ab_wrap;  // a + b reached 4 or more
  logic   q_wrap;   // adding q wrapped past line 3

  always_comb begin
    ab_dig  = '0;
    ab_wrap = 1'b0;
    for (int i = 0; i < DIG_W; i++) begin
      for (int j = 0; j < DIG_W; j++) begin
        if (a_i[i] && b_i[j]) begin
          ab_dig[(i + j) % DIG_W] = 1'b1;
          if (i + j >= DIG_W) ab_wrap = 1'b1;
        end
      end
    end
  end

  assign q_wrap = q_i & ab_dig[DIG_W-1];
  assign dig_o  = q_i ? {ab_dig[DIG_W-2:0], ab_dig[DIG_W-1]} : ab_dig;
  assign cout_o = ab_wrap | q_wrap;

  always_comb begin
    // R6: the neighbour digits must be legal one-hot codes
    a_r6_legal_digits: assert (oh_ok(a_i) && oh_ok(b_i))
      else $error("illegal one-hot digit into adder");
    if (oh_ok(a_i) && oh_ok(b_i)) begin
      // R7: the result is one-hot and the sum is conserved
      a_r7_fa_conserve: assert (oh_ok(dig_o) &&
        val_of(dig_o) + 4 * int'(cout_o) == val_of(a_i) + val_of(b_i) + int'(q_i))
        else $error("adder sum not conserved");
      // R8: the carry matches the threshold of 4
      a_r8_fa_carry: assert (cout_o == (val_of(a_i) + val_of(b_i) + int'(q_i) >= 4))
        else $error("adder carry wrong");
    end
  end

endmodule

// File: rtl/bwpc_column.sv
module bwpc_column
  import bwpc_pkg::*;
#(
  parameter int unsigned N_UNIT = 4,
  localparam int unsigned TOT_W  = $clog2(N_UNIT + 4),
  localparam int unsigned COUT_W = TOT_W - 2
) (
  input  logic              borrow_i,
  input  logic [N_UNIT-1:0] unit_i,
  input  logic              cin_i,
  input  logic [3:0]        hi2_dig_i,
  input  logic [3:0]        hi1_dig_i,
  input  logic              q_i,
  output logic [3:0]        cnt_dig_o,
  output logic [COUT_W-1:0] cnt_cout_o,
  output logic [3:0]        fa_dig_o,
  output logic              fa_cout_o
);

  logic [TOT_W-1:0] in_total;

  bwpc_in_tally #(.N_UNIT(N_UNIT), .TOT_W(TOT_W)) u_tally (
    .borrow_i (borrow_i),
    .unit_i   (unit_i),
    .cin_i    (cin_i),
    .total_o  (in_total)
  );

  bwpc_digit_split #(.TOT_W(TOT_W), .COUT_W(COUT_W)) u_split (
    .total_i (in_total),
    .dig_o   (cnt_dig_o),
    .cout_o  (cnt_cout_o)
  );

  bwpc_oh_adder u_fa (
    .a_i    (hi2_dig_i),
    .b_i    (hi1_dig_i),
    .q_i    (q_i),
    .dig_o  (fa_dig_o),
    .cout_o (fa_cout_o)
  );

  // weighted input total computed from the ports, apart from the tally chain
  int unsigned port_total;
  assign port_total = 2 * int'(borrow_i) + $countones(unit_i) + int'(cin_i);

  always_comb begin
    // R1: exactly one digit line high
    a_r1_cnt_onehot: assert ($countones(cnt_dig_o) == 1)
      else $error("counter digit not one-hot");
    // R2: weighted conservation across the counter
    a_r2_cnt_conserve: assert (val_of(cnt_dig_o) + 4 * int'(cnt_cout_o) == port_total)
      else $error("counter total not conserved");
    // R4: carry-out set exactly at totals of 4 and above
    a_r4_cnt_cout: assert ((cnt_cout_o != '0) == (port_total >= 4))
      else $error("counter carry wrong");
  end

endmodule

// File: tb/bwpc_column_tb_top.sv
`timescale 1ns/1ps
module bwpc_column_tb_top;

  localparam int NU = 4;

  logic          clk = 1'b0;
  logic          borrow = 1'b0;
  logic [NU-1:0] units = '0;
  logic          cin = 1'b0;
  logic [3:0]    hi2 = 4'b0001;
  logic [3:0]    hi1 = 4'b0001;
  logic          q = 1'b0;
  logic [3:0]    cnt_dig;
  logic [0:0]    cnt_cout;
  logic [3:0]    fa_dig;
  logic          fa_cout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference expectations, pushed at drive time and popped at check time
  int exp_cd[$];
  int exp_cc[$];
  int exp_fd[$];
  int exp_fc[$];

  always #10 clk = ~clk;  // 50 MHz

  bwpc_column #(.N_UNIT(NU)) dut_i (
    .borrow_i   (borrow),
    .unit_i     (units),
    .cin_i      (cin),
    .hi2_dig_i  (hi2),
    .hi1_dig_i  (hi1),
    .q_i        (q),
    .cnt_dig_o  (cnt_dig),
    .cnt_cout_o (cnt_cout),
    .fa_dig_o   (fa_dig),
    .fa_cout_o  (fa_cout)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one counter pattern (bits: [5]=cin [4]=borrow [3:0]=units)
  // and one adder pattern (bits: [4]=q [3:2]=hi2 value [1:0]=hi1 value)
  task automatic drive(input int cp, input int ap);
    int tot;
    int s;
    @(posedge clk);
    units  = cp[3:0];
    borrow = cp[4];
    cin    = cp[5];
    hi1    = 4'b0001 << ap[1:0];
    hi2    = 4'b0001 << ap[3:2];
    q      = ap[4];
    tot = 2 * cp[4] + cp[5] + cp[0] + cp[1] + cp[2] + cp[3];
    s   = ap[1:0] + ap[3:2] + ap[4];
    exp_cd.push_back(1 << (tot % 4));
    exp_cc.push_back(tot / 4);
    exp_fd.push_back(1 << (s % 4));
    exp_fc.push_back(s / 4);
  endtask

  task automatic check_all(input string tag);
    int e;
    @(negedge clk);
    e = exp_cd.pop_front();
    chk({tag, " R1/R3 counter digit"}, int'(cnt_dig), e);
    e = exp_cc.pop_front();
    chk({tag, " R2/R4 counter carry"}, int'(cnt_cout), e);
    e = exp_fd.pop_front();
    chk({tag, " R7 adder digit"}, int'(fa_dig), e);
    e = exp_fc.pop_front();
    chk({tag, " R8 adder carry"}, int'(fa_cout), e);
  endtask

  initial begin
    // idle state: all counter inputs low, adder digits at value 0
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 idle digit", int'(cnt_dig), 1);
    chk("R5 idle carry", int'(cnt_cout), 0);
    chk("R6 idle adder digit", int'(fa_dig), 1);

    // pass 1: every counter pattern, adder in plain order
    for (int p = 0; p < 64; p++) begin
      drive(p, p % 32);
      check_all("pass1");
    end
    // pass 2: scrambled adder order against the same counter sweep
    for (int p = 0; p < 64; p++) begin
      drive(63 - p, (p * 7 + 3) % 32);
      check_all("pass2");
    end

    // R5 extremes
    drive(0, 0);
    check_all("R5 zero");
    drive(63, 31);
    check_all("R5/R8 max");
    @(negedge clk);
    chk("R5 max digit", int'(cnt_dig), 8);
    chk("R8 max adder digit", int'(fa_dig), 8);

    // R9: move adder inputs only; counter outputs must hold
    drive(6'b010110, 0);
    check_all("R9 base");
    for (int a = 1; a < 32; a += 5) begin
      @(posedge clk);
      hi1 = 4'b0001 << a[1:0];
      hi2 = 4'b0001 << a[3:2];
      q   = a[4];
      @(negedge clk);
      chk("R9 counter digit held", int'(cnt_dig), 4'b0001);  // total 4
      chk("R9 counter carry held", int'(cnt_cout), 1);
    end
    // R9: move counter inputs only; adder outputs must hold
    drive(0, 5'b10110);  // 1 + 2 + 1 = 4
    check_all("R9 base2");
    for (int c = 1; c < 64; c += 9) begin
      @(posedge clk);
      units  = c[3:0];
      borrow = c[4];
      cin    = c[5];
      @(negedge clk);
      chk("R9 adder digit held", int'(fa_dig), 4'b0001);
      chk("R9 adder carry held", int'(fa_cout), 1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule